// File: doc/BRIEF.md
# Endpoint Zero Control Phase Sequencer

This block follows a USB control transfer on endpoint zero in hardware. A FIFO handshake unit delivers the eight setup bytes one at a time after a setup indication. The block decodes the request type, the transfer direction and the 16-bit length of the data phase. It then moves to an IN or OUT data phase, or it stays idle when there is no data phase.

During an IN data phase, each IN token makes the block read a packet of up to eight bytes from a simple byte source and pass those bytes on, one per cycle. The block ends the phase by the packet-size rules of the protocol and inserts a zero-length packet when one is needed. During an OUT data phase, it adds up the lengths of the received packets and ends the phase in the same way.

A new setup aborts any data phase that is running. A set-address request is held pending and takes effect when the status stage is reported complete. Class, vendor and reserved requests are not served: the block stalls that one transfer.

Top module: `ep0_phase_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `phase` is 0 (idle), `dev_addr` is 0, `addressed` is 0 and `stall` is 0.
- R2: Eight bytes follow `setup_start`. Bit 7 of byte 0 is the direction (1 = device to host). Byte 6 is the low byte of the length and byte 7 is the high byte. After the eighth byte, a zero length gives `phase` 0, a nonzero length with direction 1 gives `phase` 2 (IN), and a nonzero length with direction 0 gives `phase` 3 (OUT). `phase` is 1 while the setup bytes are being collected.
- R3: The byte budget of an IN phase is the smaller of the requested length and `src_avail`, sampled at decode. Each IN packet holds min(8, budget minus bytes already sent) bytes. `tx_valid` and `src_rd` are high for exactly that many cycles, `tx_data` equals `src_data`, and `pkt_end` then pulses with `pkt_len` set to the packet size.
- R4: An IN phase ends when a packet shorter than 8 bytes is sent, or when the total sent equals the requested length. At that `pkt_end`, `xfer_done` pulses and `phase` returns to 0.
- R5: After a full 8-byte IN packet that leaves the total below the requested length, `phase` stays 2. If the budget is then used up, the next packet has length 0 and ends the phase.
- R6: In the OUT phase, each `out_pkt` pulse adds `out_len` bytes. The phase ends, with `xfer_done` and `phase` 0 one cycle later, when `out_len` is below 8 or the total reaches the requested length.
- R7: If `setup_start` arrives while `phase` is 2 or 3, `xfer_abort` pulses for one cycle and `phase` becomes 1. If it arrives in any other phase, `xfer_abort` stays low.
- R8: A set-address request has byte 0 equal to 0x00, byte 1 equal to 0x05, and the address in byte 2 bits 6:0. `dev_addr` does not change until a later `status_done` pulse. `dev_addr` then takes the address, and `addressed` becomes 1 exactly when the address is nonzero. A `setup_start` before `status_done` cancels the pending address.
- R9: A request whose type field (byte 0 bits 6:5) is nonzero sets `stall` and returns `phase` to 0 without a data phase. The next `setup_start` clears `stall`, and that next request is served normally.
- R10: `in_token` outside the IN phase produces no `tx_valid` and leaves `phase` unchanged. `out_pkt` outside the OUT phase leaves `phase` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_start | input | 1 | Setup token seen; restarts byte capture |
| setup_vld | input | 1 | Setup byte valid |
| setup_byte | input | 8 | Setup byte value |
| in_token | input | 1 | Host requests the next IN packet |
| src_avail | input | 16 | Bytes the data source can supply |
| src_data | input | 8 | Current byte of the data source |
| src_rd | output | 1 | Data source advance strobe |
| tx_valid | output | 1 | Outgoing IN byte valid |
| tx_data | output | 8 | Outgoing IN byte |
| pkt_end | output | 1 | IN packet finished |
| pkt_len | output | 4 | Size of the finished IN packet |
| out_pkt | input | 1 | OUT packet received |
| out_len | input | 4 | Size of the received OUT packet |
| status_done | input | 1 | Status stage completed |
| phase | output | 2 | 0 idle, 1 setup, 2 IN data, 3 OUT data |
| stall | output | 1 | Current request is stalled |
| xfer_done | output | 1 | Data phase completed |
| xfer_abort | output | 1 | Data phase cut off by a new setup |
| dev_addr | output | 7 | Device address |
| addressed | output | 1 | Nonzero address in effect |

## Verification
IN transfers use requested lengths that are exact multiples of eight, lengths with a short tail, and source budgets below the requested length. These separate three cases: a phase that ends on the count alone, one that ends on a short packet, and one that needs a trailing zero-length packet, including the zero-budget case. OUT transfers mix full packets with early short packets, so ending on the total can be told apart from ending on a short packet. Directed cases cover aborts, the deferred address with and without cancellation, and the one-shot stall. Random transfers with expected packet sizes computed by the bench sweep lengths and budgets.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

    localparam int LEN_W       = 16;
    localparam int ADDR_W      = 7;
    localparam int SETUP_BYTES = 8;
    localparam logic [7:0] REQ_SET_ADDRESS = 8'h05;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_IN    = 2'd2,
        PH_OUT   = 2'd3
    } phase_e;

    typedef struct packed {
        logic              to_host;
        logic [1:0]        kind;
        logic [4:0]        target;
        logic [7:0]        code;
        logic [ADDR_W-1:0] new_addr;
        logic [LEN_W-1:0]  length;
    } setup_req_t;

    function automatic logic [LEN_W-1:0] len_min(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture
    import ep0_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output setup_req_t req,
    output logic       req_vld
);
    localparam int IDX_W = $clog2(SETUP_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETUP_BYTES - 1);

    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        type_q;
    logic [7:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        len_lo_q;
    logic [7:0]        len_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            req_vld <= 1'b0;
        end else begin
            req_vld <= 1'b0;
            if (start) begin
                idx_q <= '0;
            end else if (byte_vld) begin
                idx_q <= idx_q + IDX_W'(1);
                if (idx_q == LAST_IDX)
                    req_vld <= 1'b1;
            end
        end
    end

    // Only the bytes the sequencer decodes are kept.
    always_ff @(posedge clk) begin
        if (byte_vld && !start) begin
            case (idx_q)
                IDX_W'(0): type_q   <= byte_in;
                IDX_W'(1): code_q   <= byte_in;
                IDX_W'(2): addr_q   <= byte_in[ADDR_W-1:0];
                IDX_W'(6): len_lo_q <= byte_in;
                IDX_W'(7): len_hi_q <= byte_in;
                default: ;
            endcase
        end
    end

    always_comb begin
        req.to_host  = type_q[7];
        req.kind     = type_q[6:5];
        req.target   = type_q[4:0];
        req.code     = code_q;
        req.new_addr = addr_q;
        req.length   = {len_hi_q, len_lo_q};
    end

endmodule

// File: rtl/ep0_phase_fsm.sv
module ep0_phase_fsm
    import ep0_seq_pkg::*;
#(
    parameter int PKT_MAX = 8,
    parameter int CW      = $clog2(PKT_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_start,
    input  logic              req_vld,
    input  setup_req_t        req,
    input  logic              in_token,
    input  logic [LEN_W-1:0]  src_avail,
    input  logic              out_pkt,
    input  logic [CW-1:0]     out_len,
    output phase_e            phase,
    output logic              tx_valid,
    output logic              pkt_end,
    output logic [CW-1:0]     pkt_len,
    output logic              xfer_done,
    output logic              xfer_abort,
    output logic              stall,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_val
);
    localparam logic [CW-1:0]    FULL_PKT = CW'(PKT_MAX);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(PKT_MAX);

    phase_e           phase_q;
    logic [LEN_W-1:0] goal_q;
    logic [LEN_W-1:0] budget_q;
    logic [LEN_W-1:0] count_q;
    logic             busy_q;
    logic [CW-1:0]    beat_q;
    logic [CW-1:0]    blen_q;

    logic [LEN_W-1:0] remain;
    logic [CW-1:0]    next_blen;
    logic [LEN_W-1:0] in_total;
    logic             in_last;
    logic [LEN_W-1:0] out_total;
    logic             out_last;
    logic             is_set_addr;

    always_comb begin
        remain      = (budget_q > count_q) ? (budget_q - count_q) : '0;
        next_blen   = (remain >= FULL_LEN) ? FULL_PKT : CW'(remain);
        in_total    = count_q + LEN_W'(blen_q);
        in_last     = (blen_q < FULL_PKT) || (in_total == goal_q);
        out_total   = count_q + LEN_W'(out_len);
        out_last    = (out_len < FULL_PKT) || (out_total >= goal_q);
        is_set_addr = (req.kind == 2'd0) && (req.target == 5'd0) && !req.to_host
                      && (req.code == REQ_SET_ADDRESS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            goal_q     <= '0;
            budget_q   <= '0;
            count_q    <= '0;
            busy_q     <= 1'b0;
            beat_q     <= '0;
            blen_q     <= '0;
            pkt_end    <= 1'b0;
            pkt_len    <= '0;
            xfer_done  <= 1'b0;
            xfer_abort <= 1'b0;
            stall      <= 1'b0;
            addr_load  <= 1'b0;
            addr_val   <= '0;
        end else begin
            pkt_end    <= 1'b0;
            xfer_done  <= 1'b0;
            xfer_abort <= 1'b0;
            addr_load  <= 1'b0;
            if (setup_start) begin
                xfer_abort <= (phase_q == PH_IN) || (phase_q == PH_OUT);
                phase_q    <= PH_SETUP;
                stall      <= 1'b0;
                busy_q     <= 1'b0;
                count_q    <= '0;
            end else begin
                unique case (phase_q)
                    PH_SETUP: begin
                        if (req_vld) begin
                            goal_q   <= req.length;
                            budget_q <= len_min(req.length, src_avail);
                            count_q  <= '0;
                            if (req.kind != 2'd0) begin
                                stall   <= 1'b1;
                                phase_q <= PH_IDLE;
                            end else begin
                                if (is_set_addr) begin
                                    addr_load <= 1'b1;
                                    addr_val  <= req.new_addr;
                                end
                                if (req.length == '0)
                                    phase_q <= PH_IDLE;
                                else if (req.to_host)
                                    phase_q <= PH_IN;
                                else
                                    phase_q <= PH_OUT;
                            end
                        end
                    end
                    PH_IN: begin
                        if (busy_q) begin
                            if (beat_q == blen_q) begin
                                busy_q  <= 1'b0;
                                pkt_end <= 1'b1;
                                pkt_len <= blen_q;
                                count_q <= in_total;
                                if (in_last) begin
                                    phase_q   <= PH_IDLE;
                                    xfer_done <= 1'b1;
                                end
                            end else begin
                                beat_q <= beat_q + CW'(1);
                            end
                        end else if (in_token) begin
                            busy_q <= 1'b1;
                            beat_q <= '0;
                            blen_q <= next_blen;
                        end
                    end
                    PH_OUT: begin
                        if (out_pkt) begin
                            count_q <= out_total;
                            if (out_last) begin
                                phase_q   <= PH_IDLE;
                                xfer_done <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign phase    = phase_q;
    assign tx_valid = (phase_q == PH_IN) && busy_q && (beat_q < blen_q);

endmodule

// File: rtl/ep0_addr_latch.sv
module ep0_addr_latch
    import ep0_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_start,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              status_done,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              addressed
);
    logic              pend_q;
    logic [ADDR_W-1:0] pend_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
            dev_addr    <= '0;
            addressed   <= 1'b0;
        end else if (setup_start) begin
            pend_q <= 1'b0;
        end else if (load) begin
            pend_q      <= 1'b1;
            pend_addr_q <= load_addr;
        end else if (status_done && pend_q) begin
            pend_q    <= 1'b0;
            dev_addr  <= pend_addr_q;
            addressed <= |pend_addr_q;
        end
    end

endmodule

// File: rtl/ep0_phase_seq.sv
module ep0_phase_seq
    import ep0_seq_pkg::*;
#(
    parameter int PKT_MAX = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             setup_start,
    input  logic                             setup_vld,
    input  logic [7:0]                       setup_byte,
    input  logic                             in_token,
    input  logic [LEN_W-1:0]                 src_avail,
    input  logic [7:0]                       src_data,
    output logic                             src_rd,
    output logic                             tx_valid,
    output logic [7:0]                       tx_data,
    output logic                             pkt_end,
    output logic [$clog2(PKT_MAX+1)-1:0]     pkt_len,
    input  logic                             out_pkt,
    input  logic [$clog2(PKT_MAX+1)-1:0]     out_len,
    input  logic                             status_done,
    output logic [1:0]                       phase,
    output logic                             stall,
    output logic                             xfer_done,
    output logic                             xfer_abort,
    output logic [ADDR_W-1:0]                dev_addr,
    output logic                             addressed
);
    localparam int CW = $clog2(PKT_MAX + 1);

    setup_req_t        req;
    logic              req_vld;
    phase_e            phase_w;
    logic              addr_load;
    logic [ADDR_W-1:0] addr_val;
    logic              tx_vld_w;

    ep0_setup_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .start    (setup_start),
        .byte_vld (setup_vld),
        .byte_in  (setup_byte),
        .req      (req),
        .req_vld  (req_vld)
    );

    ep0_phase_fsm #(.PKT_MAX(PKT_MAX), .CW(CW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .setup_start (setup_start),
        .req_vld     (req_vld),
        .req         (req),
        .in_token    (in_token),
        .src_avail   (src_avail),
        .out_pkt     (out_pkt),
        .out_len     (out_len),
        .phase       (phase_w),
        .tx_valid    (tx_vld_w),
        .pkt_end     (pkt_end),
        .pkt_len     (pkt_len),
        .xfer_done   (xfer_done),
        .xfer_abort  (xfer_abort),
        .stall       (stall),
        .addr_load   (addr_load),
        .addr_val    (addr_val)
    );

    ep0_addr_latch u_addr (
        .clk         (clk),
        .rst         (rst),
        .setup_start (setup_start),
        .load        (addr_load),
        .load_addr   (addr_val),
        .status_done (status_done),
        .dev_addr    (dev_addr),
        .addressed   (addressed)
    );

    assign phase    = phase_w;
    assign tx_valid = tx_vld_w;
    assign src_rd   = tx_vld_w;
    assign tx_data  = src_data;

endmodule

// File: rtl/ep0_phase_seq_checks.sv
module ep0_phase_seq_checks #(
    parameter int PKT_MAX = 8,
    parameter int CW      = $clog2(PKT_MAX + 1),
    parameter int AW      = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          setup_start,
    input logic          status_done,
    input logic [1:0]    phase,
    input logic          tx_valid,
    input logic          pkt_end,
    input logic [CW-1:0] pkt_len,
    input logic          xfer_done,
    input logic          xfer_abort,
    input logic          stall,
    input logic [AW-1:0] dev_addr,
    input logic          addressed
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (phase == 2'd0 && dev_addr == '0 && !addressed && !stall));

    assert_tx_only_in_R3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> phase == 2'd2);

    assert_pkt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        pkt_end |-> pkt_len <= CW'(PKT_MAX));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> phase == 2'd0);

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |=> !xfer_abort);

    assert_abort_setup_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_abort |-> (phase == 2'd1 && $past(setup_start)));

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_addr) |-> $past(status_done));

    assert_stall_idle_R9: assert property (@(posedge clk) disable iff (rst)
        stall |-> phase == 2'd0);

endmodule

bind ep0_phase_seq ep0_phase_seq_checks #(.PKT_MAX(PKT_MAX), .CW(CW), .AW(ep0_seq_pkg::ADDR_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .setup_start (setup_start),
    .status_done (status_done),
    .phase       (phase),
    .tx_valid    (tx_valid),
    .pkt_end     (pkt_end),
    .pkt_len     (pkt_len),
    .xfer_done   (xfer_done),
    .xfer_abort  (xfer_abort),
    .stall       (stall),
    .dev_addr    (dev_addr),
    .addressed   (addressed)
);

// File: tb/ep0_phase_seq_test.sv
`timescale 1ns/1ps
module ep0_phase_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        setup_start = 1'b0;
    logic        setup_vld = 1'b0;
    logic [7:0]  setup_byte = 8'd0;
    logic        in_token = 1'b0;
    logic [15:0] src_avail = 16'd0;
    logic [7:0]  src_data = 8'd0;
    logic        src_rd;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        pkt_end;
    logic [3:0]  pkt_len;
    logic        out_pkt = 1'b0;
    logic [3:0]  out_len = 4'd0;
    logic        status_done = 1'b0;
    logic [1:0]  phase;
    logic        stall;
    logic        xfer_done;
    logic        xfer_abort;
    logic [6:0]  dev_addr;
    logic        addressed;

    int n_checks = 0;
    int n_errs   = 0;

    always #10 clk = ~clk;

    ep0_phase_seq uut (
        .clk(clk), .rst(rst), .setup_start(setup_start), .setup_vld(setup_vld),
        .setup_byte(setup_byte), .in_token(in_token), .src_avail(src_avail),
        .src_data(src_data), .src_rd(src_rd), .tx_valid(tx_valid), .tx_data(tx_data),
        .pkt_end(pkt_end), .pkt_len(pkt_len), .out_pkt(out_pkt), .out_len(out_len),
        .status_done(status_done), .phase(phase), .stall(stall), .xfer_done(xfer_done),
        .xfer_abort(xfer_abort), .dev_addr(dev_addr), .addressed(addressed)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    function automatic int exp_pkt(input int budget, input int sent);
        int r = budget - sent;
        if (r < 0) r = 0;
        return (r >= 8) ? 8 : r;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic send_setup(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [15:0] len,
                              output logic abort_seen);
        logic [7:0] bytes [8];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = 8'h00;
        bytes[4] = 8'h00; bytes[5] = 8'h00; bytes[6] = len[7:0]; bytes[7] = len[15:8];
        @(negedge clk); setup_start = 1'b1;
        @(negedge clk); setup_start = 1'b0;
        abort_seen = xfer_abort;
        chk("R2 setup collect phase", phase, 1);
        for (int i = 0; i < 8; i++) begin
            setup_vld = 1'b1; setup_byte = bytes[i];
            @(negedge clk);
        end
        setup_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic in_packet(output int len_o, output int ntx);
        ntx = 0; len_o = -1;
        @(negedge clk); in_token = 1'b1;
        @(negedge clk); in_token = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (pkt_end) begin
                len_o = pkt_len;
                break;
            end
            if (tx_valid) begin
                ntx++;
                chk("R3 src_rd follows tx_valid", src_rd, 1);
                chk("R3 tx_data from source", tx_data, src_data);
                src_data = src_data + 8'd1;
            end
            @(negedge clk);
        end
    endtask

    task automatic out_packet(input int len, output logic done_seen);
        @(negedge clk); out_pkt = 1'b1; out_len = 4'(len);
        @(negedge clk); out_pkt = 1'b0;
        done_seen = xfer_done;
    endtask

    task automatic in_transfer(input int len, input int avail);
        logic ab;
        int budget, sent, e, got, ntx;
        bit fin;
        src_avail = 16'(avail);
        send_setup(8'h80, 8'h06, 8'h00, 16'(len), ab);
        chk("R2 IN phase entered", phase, 2);
        budget = imin(len, avail);
        sent = 0;
        for (int p = 0; p < 40; p++) begin
            e = exp_pkt(budget, sent);
            in_packet(got, ntx);
            chk("R3 IN packet length", got, e);
            chk("R3 IN byte count", ntx, e);
            sent += e;
            fin = (e < 8) || (sent == len);
            chk(fin ? "R4 IN phase done" : "R5 IN phase held", phase, fin ? 0 : 2);
            chk("R4 done pulse", xfer_done, fin ? 1 : 0);
            if (fin) break;
        end
    endtask

    task automatic out_transfer(input int len, input int short_pct);
        logic ab, dn;
        int rcv, pl;
        bit fin;
        send_setup(8'h00, 8'h09, 8'h00, 16'(len), ab);
        chk("R2 OUT phase entered", phase, 3);
        rcv = 0;
        for (int p = 0; p < 40; p++) begin
            pl = imin(8, len - rcv);
            if (($urandom % 100) < short_pct) pl = $urandom % 8;
            out_packet(pl, dn);
            rcv += pl;
            fin = (pl < 8) || (rcv >= len);
            chk("R6 OUT phase", phase, fin ? 0 : 3);
            chk("R6 OUT done pulse", dn, fin ? 1 : 0);
            if (fin) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic ab, dn;
        int cnt;
        void'($urandom(32'd2718));

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 phase in reset", phase, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 phase", phase, 0);
        chk("R1 dev_addr", dev_addr, 0);
        chk("R1 addressed", addressed, 0);
        chk("R1 stall", stall, 0);

        // R10 tokens ignored while idle
        @(negedge clk); in_token = 1'b1;
        @(negedge clk); in_token = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            cnt += tx_valid;
            @(negedge clk);
        end
        chk("R10 no tx in idle", cnt, 0);
        chk("R10 idle after in_token", phase, 0);
        out_packet(8, dn);
        chk("R10 idle after out_pkt", phase, 0);

        // R2 zero length
        send_setup(8'h80, 8'h00, 8'h00, 16'd0, ab);
        chk("R2 zero length idle", phase, 0);
        chk("R7 no abort from idle", ab, 0);

        // R3 R4 R5 directed IN
        in_transfer(16, 100);
        in_transfer(20, 100);
        in_transfer(24, 16);
        in_transfer(5, 3);
        in_transfer(40, 0);
        in_transfer(8, 8);

        // R6 directed OUT
        out_transfer(10, 0);
        out_transfer(64, 30);

        // R10 in_token ignored during OUT
        send_setup(8'h00, 8'h09, 8'h00, 16'd12, ab);
        @(negedge clk); in_token = 1'b1;
        @(negedge clk); in_token = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            cnt += tx_valid;
            @(negedge clk);
        end
        chk("R10 no tx during OUT", cnt, 0);
        chk("R10 OUT phase kept", phase, 3);

        // R7 abort of OUT and of IN
        send_setup(8'h80, 8'h06, 8'h00, 16'd40, ab);
        chk("R7 abort from OUT", ab, 1);
        chk("R2 IN after abort", phase, 2);
        begin
            int g, t;
            src_avail = 16'd100;
            in_packet(g, t);
            chk("R3 first packet before abort", g, 8);
        end
        send_setup(8'h00, 8'h00, 8'h00, 16'd0, ab);
        chk("R7 abort from IN", ab, 1);
        chk("R7 idle after new request", phase, 0);

        // R8 set address, deferred
        send_setup(8'h00, 8'h05, 8'h2A, 16'd0, ab);
        chk("R8 phase idle", phase, 0);
        chk("R8 addr held before status", dev_addr, 0);
        @(negedge clk); status_done = 1'b1;
        @(negedge clk); status_done = 1'b0;
        chk("R8 addr applied", dev_addr, 42);
        chk("R8 addressed", addressed, 1);
        // pending address cancelled by a new setup
        send_setup(8'h00, 8'h05, 8'h11, 16'd0, ab);
        send_setup(8'h80, 8'h00, 8'h00, 16'd0, ab);
        @(negedge clk); status_done = 1'b1;
        @(negedge clk); status_done = 1'b0;
        chk("R8 cancelled addr", dev_addr, 42);
        // address zero
        send_setup(8'h00, 8'h05, 8'h00, 16'd0, ab);
        @(negedge clk); status_done = 1'b1;
        @(negedge clk); status_done = 1'b0;
        chk("R8 addr zero", dev_addr, 0);
        chk("R8 not addressed", addressed, 0);

        // R9 stall for vendor and class requests
        send_setup(8'h40, 8'h01, 8'h00, 16'd8, ab);
        chk("R9 stall set", stall, 1);
        chk("R9 idle on stall", phase, 0);
        send_setup(8'hA1, 8'h01, 8'h00, 16'd8, ab);
        chk("R9 class stall", stall, 1);
        in_transfer(4, 50);
        chk("R9 stall cleared", stall, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            if ($urandom % 2) in_transfer(($urandom % 50) + 1, $urandom % 60);
            else out_transfer(($urandom % 50) + 1, 15);
        end

        summary();
        $finish;
    end

endmodule